// File: doc/BRIEF.md
# DDR2 Command Sequencer with Bank Tracking

This block sits between a memory controller's scheduler and the DDR2 command pins. Each cycle it accepts at most one simple request: open a row, read, write, close one or all banks, program a mode register, refresh, enter power-down, enter self refresh, or wake up. It checks the request against the state it keeps for every bank and for the clock-enable line. A legal request is turned into the chip-select, row-strobe, column-strobe, write-enable, bank and address levels for the next command slot. An illegal request is replaced by a NOP and flagged.

The sequencer records which of the eight banks holds an open row, and which row that is. It also runs a per-bank countdown after every row activation, so that a column or close command cannot follow the activation too early. When the line is asked to go low, the sequencer picks the low-power mode from bank state: active power-down if a row is open, otherwise precharge power-down. Self refresh is entered with a refresh command in the same cycle that CKE falls. Every output is registered, so a request presented before a rising edge appears on the pins right after that edge.

Top module: `ddr2_cmd_sequencer`

## Requirements
- R1: Request codes on `req_op` are 0 NOP, 1 activate, 2 read, 3 write, 4 precharge, 5 mode load, 6 refresh, 7 power-down entry, 8 self-refresh entry, 9 exit; the pins {cs_n,ras_n,cas_n,we_n} carry 0011 activate, 0101 read, 0100 write, 0010 precharge, 0001 refresh, 0000 mode load, 0111 NOP, and 1111 when no request is valid; codes 10 to 15 are illegal.
- R2: An activate to a closed bank drives the row on the address pins and the bank on the bank pins, marks the bank open and stores the row, which `qry_row` returns for `qry_bank`; an activate to an open bank is illegal.
- R3: A read or write to an open bank drives the column with address bit 10 replaced by `req_ap`; with `req_ap` high the bank is closed after the command; a read or write to a closed bank is illegal.
- R4: A precharge with `req_ap` high drives address bit 10 high and closes every bank; with `req_ap` low it drives bit 10 low (other address bits 0) and closes only the named bank.
- R5: A mode load needs every bank closed and a bank value of 0 to 3, which it drives on the bank pins together with the address value; any other bank value is illegal.
- R6: A refresh needs every bank closed.
- R7: After an activate with `cfg_trcd` = N (N at least 1), a read, write or single-bank precharge to that bank is illegal for the next N-1 cycles and is accepted N cycles after the activate; an all-bank precharge is illegal while any bank is counting.
- R8: An illegal request drives NOP on the pins, raises `req_err` for one cycle and changes no bank or power state.
- R9: A power-down entry drives CKE low with a NOP and sets `pwr_state` to 2 (active power-down) when a row is open or to 1 (precharge power-down) when none is.
- R10: Self-refresh entry needs every bank closed; it issues the refresh command in the same cycle CKE goes low and sets `pwr_state` to 3.
- R11: While CKE is low, only exit is legal; exit drives CKE high with a NOP and sets `pwr_state` to 0; exit while awake is illegal.
- R12: After reset, CKE is high, the pins show 1111, every bank is closed, `pwr_state` is 0 and `req_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, commands registered on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 4 | Request code |
| req_bank | input | BA_W | Target bank, or mode register select |
| req_addr | input | ROW_W | Row, column or mode value |
| req_ap | input | 1 | Auto-precharge for column commands, all-bank for precharge |
| cfg_trcd | input | TMR_W | Activate-to-column delay in cycles |
| qry_bank | input | BA_W | Bank whose stored row is returned |
| qry_row | output | ROW_W | Row last activated in `qry_bank` |
| ddr_cke | output | 1 | Clock enable |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | BA_W | Bank address |
| ddr_addr | output | ROW_W | Address pins |
| bank_open | output | 2**BA_W | One bit per bank, set while a row is open |
| pwr_state | output | 2 | 0 awake, 1 precharge power-down, 2 active power-down, 3 self refresh |
| req_err | output | 1 | Previous request was rejected |

## Verification
The hardest situation to reach is the edge of the activate countdown, since it is only visible as the cycle where a rejected column command turns into an accepted one. The bench sets the delay to three, activates a bank and issues the same read on three consecutive cycles, expecting two rejections and then the read on the pins. The power states are reached by opening a bank before the power-down request and closing all banks before the second, so the same request yields both low-power modes, and self refresh is tried once with a bank open to see it refused.

// File: rtl/ddr2_cmd_sequencer.sv
module ddr2_cmd_sequencer #(
  parameter int ROW_W = 14,
  parameter int BA_W  = 3,
  parameter int TMR_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [3:0]             req_op,
  input  logic [BA_W-1:0]        req_bank,
  input  logic [ROW_W-1:0]       req_addr,
  input  logic                   req_ap,
  input  logic [TMR_W-1:0]       cfg_trcd,
  input  logic [BA_W-1:0]        qry_bank,
  output logic [ROW_W-1:0]       qry_row,
  output logic                   ddr_cke,
  output logic                   ddr_cs_n,
  output logic                   ddr_ras_n,
  output logic                   ddr_cas_n,
  output logic                   ddr_we_n,
  output logic [BA_W-1:0]        ddr_ba,
  output logic [ROW_W-1:0]       ddr_addr,
  output logic [(1<<BA_W)-1:0]   bank_open,
  output logic [1:0]             pwr_state,
  output logic                   req_err
);
  localparam int NB = 1 << BA_W;

  localparam logic [3:0] OP_NOP = 4'd0, OP_ACT = 4'd1, OP_RD = 4'd2, OP_WR = 4'd3,
                         OP_PRE = 4'd4, OP_LMR = 4'd5, OP_REF = 4'd6, OP_PDE = 4'd7,
                         OP_SRE = 4'd8, OP_EXIT = 4'd9;

  localparam logic [3:0] C_DESEL = 4'b1111, C_NOP = 4'b0111, C_ACT = 4'b0011,
                         C_RD = 4'b0101, C_WR = 4'b0100, C_PRE = 4'b0010,
                         C_REF = 4'b0001, C_LMR = 4'b0000;

  localparam logic [1:0] PS_AWAKE = 2'd0, PS_PPD = 2'd1, PS_APD = 2'd2, PS_SR = 2'd3;

  logic [ROW_W-1:0] row_q [NB];
  logic [TMR_W-1:0] tmr_q [NB];
  logic [NB-1:0]    busy;
  logic             legal;
  logic [3:0]       cmd_d;
  logic [ROW_W-1:0] addr_d;
  logic [BA_W-1:0]  ba_d;

  for (genvar g = 0; g < NB; g++) begin : g_busy
    assign busy[g] = |tmr_q[g];
  end

  wire awake    = pwr_state == PS_AWAKE;
  wire all_idle = ~|bank_open;
  wire sel_open = bank_open[req_bank];
  wire sel_busy = busy[req_bank];
  wire mr_ok    = (req_bank >> 2) == '0;
  wire go       = req_valid & legal;
  wire [TMR_W-1:0] trcd_load = (cfg_trcd == '0) ? '0 : cfg_trcd - 1'b1;

  assign qry_row = row_q[qry_bank];

  always_comb begin
    case (req_op)
      OP_NOP, OP_PDE: legal = awake;
      OP_ACT:         legal = awake & ~sel_open;
      OP_RD, OP_WR:   legal = awake & sel_open & ~sel_busy;
      OP_PRE:         legal = awake & (req_ap ? ~|busy : ~sel_busy);
      OP_LMR:         legal = awake & all_idle & mr_ok;
      OP_REF, OP_SRE: legal = awake & all_idle;
      OP_EXIT:        legal = ~awake;
      default:        legal = 1'b0;
    endcase
  end

  always_comb begin
    cmd_d  = C_DESEL;
    addr_d = '0;
    ba_d   = '0;
    if (req_valid && !legal) begin
      cmd_d = C_NOP;
    end else if (go) begin
      case (req_op)
        OP_ACT: begin
          cmd_d  = C_ACT;
          addr_d = req_addr;
          ba_d   = req_bank;
        end
        OP_RD, OP_WR: begin
          cmd_d      = (req_op == OP_RD) ? C_RD : C_WR;
          addr_d     = req_addr;
          addr_d[10] = req_ap;
          ba_d       = req_bank;
        end
        OP_PRE: begin
          cmd_d      = C_PRE;
          addr_d[10] = req_ap;
          ba_d       = req_ap ? '0 : req_bank;
        end
        OP_LMR: begin
          cmd_d  = C_LMR;
          addr_d = req_addr;
          ba_d   = req_bank;
        end
        OP_REF, OP_SRE: cmd_d = C_REF;
        default:        cmd_d = C_NOP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} <= C_DESEL;
      ddr_ba    <= '0;
      ddr_addr  <= '0;
      req_err   <= 1'b0;
      ddr_cke   <= 1'b1;
      pwr_state <= PS_AWAKE;
    end else begin
      {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} <= cmd_d;
      ddr_ba   <= ba_d;
      ddr_addr <= addr_d;
      req_err  <= req_valid & ~legal;
      if (go) begin
        case (req_op)
          OP_PDE: begin
            ddr_cke   <= 1'b0;
            pwr_state <= all_idle ? PS_PPD : PS_APD;
          end
          OP_SRE: begin
            ddr_cke   <= 1'b0;
            pwr_state <= PS_SR;
          end
          OP_EXIT: begin
            ddr_cke   <= 1'b1;
            pwr_state <= PS_AWAKE;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_open <= '0;
      for (int i = 0; i < NB; i++) begin
        row_q[i] <= '0;
        tmr_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NB; i++) begin
        if (busy[i]) tmr_q[i] <= tmr_q[i] - 1'b1;
        if (go) begin
          case (req_op)
            OP_ACT:
              if (req_bank == BA_W'(i)) begin
                bank_open[i] <= 1'b1;
                row_q[i]     <= req_addr;
                tmr_q[i]     <= trcd_load;
              end
            OP_RD, OP_WR:
              if (req_ap && req_bank == BA_W'(i)) bank_open[i] <= 1'b0;
            OP_PRE:
              if (req_ap || req_bank == BA_W'(i)) bank_open[i] <= 1'b0;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/ddr2_cmd_sequencer_chk.sv
module ddr2_cmd_sequencer_chk #(
  parameter int ROW_W = 14,
  parameter int BA_W  = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ddr_cke,
  input logic                 ddr_cs_n,
  input logic                 ddr_ras_n,
  input logic                 ddr_cas_n,
  input logic                 ddr_we_n,
  input logic [BA_W-1:0]      ddr_ba,
  input logic [ROW_W-1:0]     ddr_addr,
  input logic [(1<<BA_W)-1:0] bank_open,
  input logic [1:0]           pwr_state,
  input logic                 req_err
);
  logic [(1<<BA_W)-1:0] prev_open;
  wire  [3:0] cmd = {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_open <= '0;
    else        prev_open <= bank_open;

  p_act_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 4'b0011 |-> !prev_open[ddr_ba] && bank_open[ddr_ba]);

  p_col_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0101 || cmd == 4'b0100) |-> prev_open[ddr_ba]);

  p_pre_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0010 && ddr_addr[10]) |-> bank_open == '0);

  p_mode_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 4'b0000 |-> prev_open == '0 && (ddr_ba >> 2) == '0);

  p_err_nop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> cmd == 4'b0111 && $stable(bank_open) && $stable(pwr_state));

  p_cke_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ddr_cke == (pwr_state == 2'd0));

  p_sr_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ddr_cke) && pwr_state == 2'd3) |-> cmd == 4'b0001 && prev_open == '0);

  p_sleep_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ddr_cke && !$past(ddr_cke)) |-> ddr_ras_n && ddr_cas_n && ddr_we_n);
endmodule

bind ddr2_cmd_sequencer ddr2_cmd_sequencer_chk #(.ROW_W(ROW_W), .BA_W(BA_W)) u_chk (.*);

// File: tb/ddr2_cmd_sequencer_test.sv
`timescale 1ns/1ps
module ddr2_cmd_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_op = '0;
  logic [2:0]  req_bank = '0;
  logic [13:0] req_addr = '0;
  logic        req_ap = 1'b0;
  logic [3:0]  cfg_trcd = 4'd3;
  logic [2:0]  qry_bank = '0;
  logic [13:0] qry_row;
  logic        ddr_cke, ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n;
  logic [2:0]  ddr_ba;
  logic [13:0] ddr_addr;
  logic [7:0]  bank_open;
  logic [1:0]  pwr_state;
  logic        req_err;
  int total = 0;
  int fails = 0;

  always #4 clk = ~clk;

  ddr2_cmd_sequencer uut (.*);

  wire [3:0] cmd = {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n};

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [3:0] op, logic [2:0] bank, logic [13:0] addr, logic ap);
    req_valid = 1'b1; req_op = op; req_bank = bank; req_addr = addr; req_ap = ap;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic t_reset;
    chk("R12 cke", ddr_cke, 1);
    chk("R12 pins", cmd, 4'b1111);
    chk("R12 banks", bank_open, 0);
    chk("R12 pwr", pwr_state, 0);
    chk("R12 err", req_err, 0);
  endtask

  task automatic t_activate;
    cfg_trcd = 4'd2;
    issue(4'd1, 3'd3, 14'h1A5A, 1'b0);
    chk("R1 act pins", cmd, 4'b0011);
    chk("R2 act addr", ddr_addr, 14'h1A5A);
    chk("R2 act ba", ddr_ba, 3);
    chk("R2 open", bank_open, 8'h08);
    qry_bank = 3'd3; #1;
    chk("R2 row record", qry_row, 14'h1A5A);
    issue(4'd1, 3'd3, 14'h0001, 1'b0);
    chk("R2 reopen err", req_err, 1);
    chk("R8 nop", cmd, 4'b0111);
    #1 chk("R8 row kept", qry_row, 14'h1A5A);
    idle(1);
    chk("R1 idle deselect", cmd, 4'b1111);
    chk("R8 err drops", req_err, 0);
    issue(4'd12, 3'd0, 14'h0, 1'b0);
    chk("R1 bad code", req_err, 1);
  endtask

  task automatic t_trcd;
    cfg_trcd = 4'd3;
    issue(4'd1, 3'd5, 14'h0123, 1'b0);
    issue(4'd2, 3'd5, 14'h0010, 1'b0);
    chk("R7 early rd 1", req_err, 1);
    issue(4'd2, 3'd5, 14'h0010, 1'b0);
    chk("R7 early rd 2", req_err, 1);
    issue(4'd2, 3'd5, 14'h0010, 1'b0);
    chk("R7 rd at delay", cmd, 4'b0101);
    chk("R7 no err", req_err, 0);
    issue(4'd1, 3'd0, 14'h0077, 1'b0);
    issue(4'd4, 3'd0, 14'h0, 1'b0);
    chk("R7 early pre", req_err, 1);
    chk("R7 bank kept", bank_open, 8'h29);
    idle(2);
    issue(4'd4, 3'd0, 14'h0, 1'b0);
    chk("R7 pre ok", cmd, 4'b0010);
    chk("R7 pre closes", bank_open, 8'h28);
  endtask

  task automatic t_column;
    issue(4'd3, 3'd3, 14'h07FF, 1'b0);
    chk("R1 wr pins", cmd, 4'b0100);
    chk("R3 wr a10 low", ddr_addr, 14'h03FF);
    chk("R3 wr keeps open", bank_open, 8'h28);
    issue(4'd2, 3'd3, 14'h0055, 1'b1);
    chk("R3 rd ap addr", ddr_addr, 14'h0455);
    chk("R3 ap closes", bank_open, 8'h20);
    issue(4'd2, 3'd3, 14'h0055, 1'b0);
    chk("R3 rd idle err", req_err, 1);
  endtask

  task automatic t_precharge;
    issue(4'd1, 3'd1, 14'h0007, 1'b0);
    idle(3);
    issue(4'd4, 3'd1, 14'h3FFF, 1'b0);
    chk("R4 single pins", cmd, 4'b0010);
    chk("R4 single a10", ddr_addr, 14'h0000);
    chk("R4 single ba", ddr_ba, 1);
    chk("R4 single closes", bank_open, 8'h20);
    issue(4'd1, 3'd2, 14'h0009, 1'b0);
    idle(3);
    issue(4'd4, 3'd6, 14'h0000, 1'b1);
    chk("R4 all a10", ddr_addr, 14'h0400);
    chk("R4 all closes", bank_open, 8'h00);
  endtask

  task automatic t_mode;
    issue(4'd5, 3'd2, 14'h0042, 1'b0);
    chk("R5 lmr pins", cmd, 4'b0000);
    chk("R5 lmr ba", ddr_ba, 2);
    chk("R5 lmr addr", ddr_addr, 14'h0042);
    issue(4'd5, 3'd5, 14'h0042, 1'b0);
    chk("R5 bad select", req_err, 1);
    issue(4'd1, 3'd6, 14'h0100, 1'b0);
    idle(3);
    issue(4'd5, 3'd0, 14'h0001, 1'b0);
    chk("R5 lmr open err", req_err, 1);
    issue(4'd6, 3'd0, 14'h0, 1'b0);
    chk("R6 ref open err", req_err, 1);
    issue(4'd4, 3'd0, 14'h0, 1'b1);
    issue(4'd6, 3'd0, 14'h0, 1'b0);
    chk("R6 ref pins", cmd, 4'b0001);
    chk("R6 ref ok", req_err, 0);
  endtask

  task automatic t_power;
    issue(4'd1, 3'd4, 14'h0AAA, 1'b0);
    idle(3);
    issue(4'd7, 3'd0, 14'h0, 1'b0);
    chk("R9 cke low", ddr_cke, 0);
    chk("R9 active pd", pwr_state, 2);
    chk("R9 nop", cmd, 4'b0111);
    issue(4'd2, 3'd4, 14'h0, 1'b0);
    chk("R11 asleep rd err", req_err, 1);
    chk("R11 cke held", ddr_cke, 0);
    issue(4'd9, 3'd0, 14'h0, 1'b0);
    chk("R11 exit cke", ddr_cke, 1);
    chk("R11 exit pwr", pwr_state, 0);
    chk("R11 exit nop", cmd, 4'b0111);
    issue(4'd8, 3'd0, 14'h0, 1'b0);
    chk("R10 sr open err", req_err, 1);
    chk("R10 cke stays", ddr_cke, 1);
    issue(4'd4, 3'd0, 14'h0, 1'b1);
    issue(4'd7, 3'd0, 14'h0, 1'b0);
    chk("R9 precharge pd", pwr_state, 1);
    issue(4'd9, 3'd0, 14'h0, 1'b0);
    issue(4'd8, 3'd0, 14'h0, 1'b0);
    chk("R10 sr cke", ddr_cke, 0);
    chk("R10 sr ref", cmd, 4'b0001);
    chk("R10 sr pwr", pwr_state, 3);
    issue(4'd9, 3'd0, 14'h0, 1'b0);
    chk("R11 sr exit", ddr_cke, 1);
    issue(4'd9, 3'd0, 14'h0, 1'b0);
    chk("R11 exit awake err", req_err, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_activate();
    t_trcd();
    t_column();
    t_precharge();
    t_mode();
    t_power();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule